// File: doc/BRIEF.md
# Accumulator-Controlled Fractional-N Divider

This block divides a fast oscillator clock by a ratio that is not a whole number. A counter divides by either P or P+1. An accumulator that wraps at 223 decides which of the two each division cycle uses. Over many cycles the average ratio is P + Q/223. With a 557.5 kHz comparison rate, each step of Q moves the oscillator by 2.5 kHz.

The block sends one single-clock pulse per division cycle to a phase comparator. The integer setting P and the fractional setting Q may change at any time. The block samples them only at the start of a cycle, so no cycle mixes two settings. Reset clears the accumulator. The first cycle begins on the first clock edge after reset is released.

Top module: `fracn_divider`

## Requirements
- R1: Over 223 consecutive cycles with fixed settings, the input clocks add up to exactly 223·P + Q, which is an average ratio of P + Q/223.
- R2: At each cycle boundary the accumulator adds Q and always stays in the range 0 to 222. With Q = 222, exactly 222 of any 223 consecutive cycles are long.
- R3: When the sum reaches or passes 223, the cycle that starts lasts P+1 clocks, and the accumulator keeps the sum minus 223.
- R4: When the sum stays below 223, the cycle that starts lasts P clocks, and the accumulator keeps the sum.
- R5: With fixed settings, exactly Q of any 223 consecutive cycles last P+1 clocks. This also holds for Q = 0.
- R6: Q is 8 bits wide. A value of 223 or more acts as 222.
- R7: P is 10 bits wide. A value below 4 acts as 4. P = 1023 with a carry gives a 1024-clock cycle.
- R8: P and Q are sampled only on the edge that starts a cycle. A change in the middle of a cycle leaves that cycle's length unchanged and takes effect from the next cycle.
- R9: The output pulse is high for exactly one clock, which is the last clock of each cycle. There is one pulse per cycle.
- R10: While reset is low, the output pulse is low and the accumulator is cleared. After release, the first cycle starts on the first edge and its length comes from an accumulator starting at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| div_int | input | 10 | Integer division setting P |
| div_frac | input | 8 | Fractional setting Q (0 to 222) |
| ref_pulse | output | 1 | One-clock pulse on the last clock of every division cycle |

## Verification
The bench measures the length of every division cycle and compares it with a model of the wrapping accumulator. It uses several kinds of settings:
- Q = 0 shows that the divider never adds a long cycle by mistake.
- Q = 222 shows that the accumulator wraps nearly every cycle and that the leftover value is carried correctly.
- Mid-range values of Q show that long and short cycles interleave in the right order.
- Out-of-range P and Q show that the clamps work.
- P = 1023 shows the widest modulus.

Changing the settings in the middle of a cycle shows that the cycle length is sampled at the boundary. A reset in the middle of a run shows that the accumulator restarts from zero. Counting long cycles over a window of 223 shows the exact fractional average.

// File: rtl/fracn_pkg.sv
// Package: shared defaults and the modulus-select type for the fractional-N divider.
// Assumes nothing beyond the parameters in the top module using the same defaults.
package fracn_pkg;
    // Default fractional modulus; the accumulator wraps at this value.
    localparam int FRAC_MOD_DEF = 223;
    // Smallest integer modulus the counter supports.
    localparam int P_MIN_DEF    = 4;

    // Which modulus the next division cycle uses.
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_PLUS1 = 1'b1
    } mod_sel_e;
endpackage

// File: rtl/fracn_clamp.sv
// Module: fracn_clamp
// Purpose: forces the requested P and Q into their legal ranges.
// Assumes: FRAC_MOD - 1 fits in Q_W bits and P_MIN fits in P_W bits.
module fracn_clamp #(
    parameter int P_W      = 10,
    parameter int Q_W      = 8,
    parameter int FRAC_MOD = 223,
    parameter int P_MIN    = 4
) (
    input  logic [P_W-1:0] p_raw,
    input  logic [Q_W-1:0] q_raw,
    output logic [P_W-1:0] p_eff,
    output logic [Q_W-1:0] q_eff
);
    localparam logic [Q_W-1:0] Q_LIMIT = Q_W'(FRAC_MOD);
    localparam logic [Q_W-1:0] Q_TOP   = Q_W'(FRAC_MOD - 1);
    localparam logic [P_W-1:0] P_FLOOR = P_W'(P_MIN);

    // Raise P to the minimum and cap Q just below the modulus.
    always_comb begin
        p_eff = (p_raw < P_FLOOR) ? P_FLOOR : p_raw;
        q_eff = (q_raw >= Q_LIMIT) ? Q_TOP : q_raw;
    end
endmodule

// File: rtl/fracn_accum.sv
// Module: fracn_accum
// Purpose: the phase accumulator that wraps at FRAC_MOD. It flags a carry when the
// running sum reaches the modulus and keeps only the excess.
// Assumes: q_val < FRAC_MOD, and step pulses once per division cycle.
module fracn_accum #(
    parameter int Q_W      = 8,
    parameter int FRAC_MOD = 223
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic [Q_W-1:0]      q_val,
    output fracn_pkg::mod_sel_e sel,
    output logic [Q_W-1:0]      acc
);
    import fracn_pkg::*;

    localparam int SW = Q_W + 1;
    localparam logic [SW-1:0] MOD_W = SW'(FRAC_MOD);

    logic [SW-1:0]  sum;
    logic           carry;
    logic [Q_W-1:0] acc_nxt;

    // Candidate sum, the wrap decision and the value left after the wrap.
    always_comb begin
        sum     = {1'b0, acc} + {1'b0, q_val};
        carry   = (sum >= MOD_W);
        acc_nxt = carry ? Q_W'(sum - MOD_W) : sum[Q_W-1:0];
        sel     = carry ? SEL_PLUS1 : SEL_BASE;
    end

    // Update the accumulator once per cycle boundary; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (step) begin
            acc <= acc_nxt;
        end
    end
endmodule

// File: rtl/fracn_count.sv
// Module: fracn_count
// Purpose: counts up through one division cycle of length mod_cur. It raises term on
// the last count and reloads at the boundary with the modulus for the next cycle.
// Assumes: mod_in >= 1. After reset, term is high, so the first edge is a boundary.
module fracn_count #(
    parameter int P_W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [P_W:0] mod_in,
    output logic         term,
    output logic [P_W:0] mod_cur
);
    localparam int MW = P_W + 1;

    logic [MW-1:0] cnt;
    logic [MW-1:0] last_cnt;

    // Index of the final clock in the current cycle.
    always_comb begin
        last_cnt = mod_cur - MW'(1);
        term     = (cnt == last_cnt);
    end

    // Count through the cycle; latch the new modulus at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            mod_cur <= MW'(1);
        end else if (load) begin
            cnt     <= '0;
            mod_cur <= mod_in;
        end else begin
            cnt     <= cnt + MW'(1);
        end
    end
endmodule

// File: rtl/fracn_divider.sv
// Module: fracn_divider (top)
// Purpose: a fractional-N divider. Its average ratio is div_int + div_frac/FRAC_MOD.
// Every cycle lasts either P or P+1 input clocks, as the wrapping accumulator picks.
// ref_pulse marks the last clock of each cycle.
// Assumes: settings may change at any time. They are sampled only on the boundary edge.
module fracn_divider #(
    parameter int P_W      = 10,
    parameter int Q_W      = 8,
    parameter int FRAC_MOD = fracn_pkg::FRAC_MOD_DEF,
    parameter int P_MIN    = fracn_pkg::P_MIN_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P_W-1:0] div_int,
    input  logic [Q_W-1:0] div_frac,
    output logic           ref_pulse
);
    import fracn_pkg::*;

    localparam int MW = P_W + 1;

    logic [P_W-1:0] p_eff;
    logic [Q_W-1:0] q_eff;
    mod_sel_e       sel;
    logic [Q_W-1:0] acc_val;
    logic           boundary;
    logic [MW-1:0]  mod_next;
    logic [MW-1:0]  mod_cur;
    logic           primed;

    fracn_clamp #(
        .P_W(P_W), .Q_W(Q_W), .FRAC_MOD(FRAC_MOD), .P_MIN(P_MIN)
    ) u_clamp (
        .p_raw(div_int),
        .q_raw(div_frac),
        .p_eff(p_eff),
        .q_eff(q_eff)
    );

    fracn_accum #(
        .Q_W(Q_W), .FRAC_MOD(FRAC_MOD)
    ) u_accum (
        .clk(clk),
        .rst_n(rst_n),
        .step(boundary),
        .q_val(q_eff),
        .sel(sel),
        .acc(acc_val)
    );

    // Modulus for the cycle about to start: P, plus one when the accumulator wraps.
    always_comb begin
        mod_next = {1'b0, p_eff} + ((sel == SEL_PLUS1) ? MW'(1) : MW'(0));
    end

    fracn_count #(
        .P_W(P_W)
    ) u_count (
        .clk(clk),
        .rst_n(rst_n),
        .load(boundary),
        .mod_in(mod_next),
        .term(boundary),
        .mod_cur(mod_cur)
    );

    // Block the pulse on the start-up boundary that comes right after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed <= 1'b0;
        end else begin
            primed <= 1'b1;
        end
    end

    // One pulse on the final clock of every real division cycle.
    always_comb begin
        ref_pulse = boundary & primed;
    end
endmodule

// File: rtl/fracn_divider_chk.sv
// Module: fracn_divider_chk
// Purpose: temporal checks on the divider's internal handshakes. It is bound to the top.
// Assumes: it is connected through the bind below; it drives nothing.
module fracn_divider_chk #(
    parameter int P_W      = 10,
    parameter int Q_W      = 8,
    parameter int FRAC_MOD = 223,
    parameter int P_MIN    = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pulse,
    input logic           bound,
    input logic           wrap,
    input logic [Q_W-1:0] acc,
    input logic [Q_W-1:0] q_eff,
    input logic [P_W:0]   mod_cur
);
    // R2: the accumulator never holds the modulus or more.
    p_acc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc < Q_W'(FRAC_MOD));

    // R3: after a wrap, the leftover value is smaller than the step just added.
    p_wrap_excess_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bound && wrap) |=> (acc < $past(q_eff)));

    // R3: a wrap makes the new cycle one longer than the minimum.
    p_wrap_long_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bound && wrap) |=> (mod_cur >= (P_W+1)'(P_MIN + 1)));

    // R4: without a wrap, the accumulator grows by exactly the step.
    p_nowrap_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bound && !wrap) |=> ({1'b0, acc} == {1'b0, $past(acc)} + {1'b0, $past(q_eff)}));

    // R6: the clamped Q is always below the modulus.
    p_q_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q_eff < Q_W'(FRAC_MOD));

    // R7: a loaded modulus is never below the minimum P.
    p_p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bound |=> (mod_cur >= (P_W+1)'(P_MIN)));

    // R8: the modulus and the accumulator stay fixed inside a cycle.
    p_mod_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bound |=> ($stable(mod_cur) && $stable(acc)));

    // R9: the pulse is never longer than one clock.
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

bind fracn_divider fracn_divider_chk #(
    .P_W(P_W), .Q_W(Q_W), .FRAC_MOD(FRAC_MOD), .P_MIN(P_MIN)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .pulse(ref_pulse),
    .bound(boundary),
    .wrap(sel == fracn_pkg::SEL_PLUS1),
    .acc(acc_val),
    .q_eff(q_eff),
    .mod_cur(mod_cur)
);

// File: tb/fracn_divider_bench.sv
module fracn_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] div_int;
    logic [7:0] div_frac;
    logic       ref_pulse;

    always #10 clk = ~clk;

    fracn_divider u_fracn_divider (
        .clk(clk),
        .rst_n(rst_n),
        .div_int(div_int),
        .div_frac(div_frac),
        .ref_pulse(ref_pulse)
    );

    int    total = 0;
    int    bad = 0;
    int    acc_m = 0;
    int    exp_len = 0;
    bit    exp_long = 1'b0;
    int    elapsed = 0;
    bit    pend = 1'b0;
    int    pulses = 0;
    int    long_cnt = 0;
    int    clk_sum = 0;
    string tag_next = "";
    bit    done = 1'b0;

    // Each entry is {P[31:22], Q[21:14], number of pulses[13:0]}.
    localparam int NV = 9;
    localparam logic [31:0] VEC [NV] = '{
        {10'd10,   8'd0,   14'd12},
        {10'd4,    8'd222, 14'd40},
        {10'd7,    8'd111, 14'd30},
        {10'd100,  8'd50,  14'd10},
        {10'd5,    8'd255, 14'd30},
        {10'd2,    8'd30,  14'd30},
        {10'd0,    8'd1,   14'd10},
        {10'd1023, 8'd200, 14'd4},
        {10'd1023, 8'd222, 14'd4}
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One clock. At a boundary the model picks the next cycle's length from the inputs as they stand.
    task automatic tick();
        if (pend) begin
            int p;
            int q;
            p = (int'(div_int) < 4) ? 4 : int'(div_int);     // R7 clamp
            q = (int'(div_frac) >= 223) ? 222 : int'(div_frac); // R6 clamp
            acc_m += q;
            if (acc_m >= 223) begin
                acc_m -= 223;
                exp_len = p + 1;
                exp_long = 1'b1;
            end else begin
                exp_len = p;
                exp_long = 1'b0;
            end
            pend = 1'b0;
        end
        @(negedge clk);
        elapsed++;
        if (ref_pulse) begin
            string t;
            t = (tag_next != "") ? tag_next : (exp_long ? "R3" : "R4");
            check(elapsed == exp_len, t, elapsed, exp_len);
            tag_next = "";
            if (exp_long) long_cnt++;
            clk_sum += elapsed;
            pulses++;
            pend = 1'b1;
            elapsed = 0;
        end else if (elapsed > exp_len) begin
            check(1'b0, "R9 missing pulse", elapsed, exp_len);
            pend = 1'b1;
            elapsed = 0;
        end
    endtask

    task automatic run_pulses(input int n);
        int target;
        target = pulses + n;
        while (pulses < target) tick();
    endtask

    // R10: the pulse stays low during reset, and the model restarts from a cleared accumulator.
    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(ref_pulse == 1'b0, "R10 pulse in reset", int'(ref_pulse), 0);
        end
        rst_n = 1'b1;
        acc_m = 0;
        pend = 1'b1;
        elapsed = 0;
        tag_next = "R10";
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        div_int = 10'd10;
        div_frac = 8'd0;
        do_reset();

        // Walk the vector table.
        for (int v = 0; v < NV; v++) begin
            div_int  = VEC[v][31:22];
            div_frac = VEC[v][21:14];
            run_pulses(int'(VEC[v][13:0]));
        end

        // R5 and R1: a window of 223 cycles at P=6, Q=77.
        div_int = 10'd6;
        div_frac = 8'd77;
        run_pulses(1);
        long_cnt = 0;
        clk_sum = 0;
        run_pulses(223);
        check(long_cnt == 77, "R5 long count", long_cnt, 77);
        check(clk_sum == 223 * 6 + 77, "R1 total clocks", clk_sum, 223 * 6 + 77);

        // R5 with Q=0: no long cycles.
        div_frac = 8'd0;
        run_pulses(1);
        long_cnt = 0;
        run_pulses(223);
        check(long_cnt == 0, "R5 zero fraction", long_cnt, 0);

        // R2 with Q=222: the accumulator wraps on 222 of 223 cycles.
        div_frac = 8'd222;
        run_pulses(1);
        long_cnt = 0;
        run_pulses(223);
        check(long_cnt == 222, "R2 near-full step", long_cnt, 222);

        // R9: the pulse is exactly one clock wide.
        div_int = 10'd12;
        div_frac = 8'd40;
        run_pulses(1);
        tick();
        check(ref_pulse == 1'b0, "R9 pulse width", int'(ref_pulse), 0);

        // R8: change the settings in the middle of a cycle.
        div_int = 10'd20;
        div_frac = 8'd100;
        run_pulses(2);
        tick();
        tick();
        div_int = 10'd9;
        div_frac = 8'd5;
        tag_next = "R8";
        run_pulses(4);

        // R10: reset in the middle of a run, then a fresh start with P=8, Q=150.
        div_int = 10'd8;
        div_frac = 8'd150;
        run_pulses(5);
        tick();
        tick();
        tick();
        do_reset();
        run_pulses(6);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule